// File: doc/BRIEF.md
# Phase-Accumulator Square-Wave Generator

This block is a numerically controlled oscillator that turns a fixed system clock into a square wave whose frequency is set by two numbers: a step and a modulus. On every clock the step is added to an accumulator. The accumulator wraps when it reaches the modulus. The output frequency is the clock frequency multiplied by step/modulus. The square wave is high while the accumulator sits in the upper half of its range. A one-clock pulse marks every wrap.

Two wrap modes are available through a mode pin. In binary mode the modulus is fixed at 2^ACC_W, so the square wave is the top bit of the accumulator. In arbitrary mode the modulus comes from an input port, which gives an exact N/M frequency ratio for any N and M. New step and modulus values are captured only when the accumulator wraps, so a frequency change never produces a runt cycle.

Top module: `nco_sqwave`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, drives `sq_out` and `wrap_pulse` low on the next clock, and captures the current step, modulus and mode.
- R2: Over n clocks after reset, starting from an accumulator of zero, the number of wrap pulses is floor(n*step/M), so the mean output frequency is f_clk*step/M.
- R3: With `bin_mode`=1 the modulus is 2^ACC_W and `modulus_in` has no effect. `sq_out` then follows accumulator bit ACC_W-1.
- R4: With `bin_mode`=0 the next accumulator value is acc+step-M when acc+step >= M, and acc+step otherwise. The square wave is high while acc >= floor(M/2).
- R5: When M/step is an integer, every interval between wrap pulses equals M/step clocks. Otherwise the intervals take only the two values floor(M/step) and ceil(M/step).
- R6: A step at or above floor(M/2) is captured as floor(M/2)-1. If floor(M/2) is zero, it is captured as 0.
- R7: A captured step of zero holds `sq_out` low and produces no wrap pulses. While the held step is zero, the inputs are captured on every clock.
- R8: If the held step is nonzero, the step, modulus and mode are captured only at the clock edge on which the accumulator wraps. That includes a change that is presented just before that edge.
- R9: `sq_out` and `wrap_pulse` are registered. `wrap_pulse` is high for exactly one clock per wrap, on the clock edge where the wrapping addition takes effect. `sq_out` at each edge reflects the accumulator value held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bin_mode | input | 1 | 1: wrap at 2^ACC_W; 0: wrap at `modulus_in` |
| step_in | input | ACC_W | Phase increment added each clock |
| modulus_in | input | ACC_W | Wrap modulus for arbitrary mode |
| sq_out | output | 1 | Square-wave output |
| wrap_pulse | output | 1 | One-clock pulse per accumulator wrap |

## Verification
Two functions can land on the same clock edge: an accumulator wrap, and the capture of a new step. The bench predicts the edge of the next wrap from the regular period. It changes `step_in` one clock before that edge, so the wrap and the capture share the edge. The result is judged by the wrap pulse appearing on that edge and the following interval matching the new step. A second run changes the step a few clocks after a wrap. There the bench checks that the old interval finishes in full before the new one begins.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic {
    WRAP_ARB = 1'b0,
    WRAP_BIN = 1'b1
  } wrap_mode_e;

endpackage

// File: rtl/nco_cfg_hold.sv
module nco_cfg_hold #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             bin_mode,
  input  logic [ACC_W-1:0] step_in,
  input  logic [ACC_W-1:0] modulus_in,
  output logic [ACC_W-1:0] step_q,
  output logic [ACC_W-1:0] half_q,
  output logic [ACC_W:0]   mod_q
);
  import nco_pkg::*;

  localparam int MOD_W = ACC_W + 1;

  wrap_mode_e       mode_sel;
  logic [MOD_W-1:0] mod_eff;
  logic [ACC_W-1:0] half_eff;
  logic [ACC_W-1:0] step_lim;
  logic [ACC_W-1:0] step_eff;

  always_comb begin
    mode_sel = wrap_mode_e'(bin_mode);
    case (mode_sel)
      WRAP_BIN: mod_eff = MOD_W'(1) << ACC_W;
      default:  mod_eff = {1'b0, modulus_in};
    endcase
    half_eff = mod_eff[MOD_W-1:1];
    step_lim = (half_eff == '0) ? '0 : half_eff - ACC_W'(1);
    step_eff = (step_in > step_lim) ? step_lim : step_in;
  end

  always_ff @(posedge clk) begin
    if (rst || load_en) begin
      step_q <= step_eff;
      half_q <= half_eff;
      mod_q  <= mod_eff;
    end
  end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step_q,
  input  logic [ACC_W:0]   mod_q,
  output logic [ACC_W-1:0] acc,
  output logic             wrap_now
);
  localparam int MOD_W = ACC_W + 1;

  logic [MOD_W-1:0] sum;
  logic [ACC_W-1:0] acc_nx;

  always_comb begin
    sum      = {1'b0, acc} + {1'b0, step_q};
    wrap_now = (step_q != '0) && (sum >= mod_q);
    acc_nx   = wrap_now ? ACC_W'(sum - mod_q) : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc_nx;
  end

endmodule

// File: rtl/nco_edge_out.sv
module nco_edge_out #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] half_q,
  input  logic [ACC_W-1:0] step_q,
  input  logic             wrap_now,
  output logic             sq_out,
  output logic             wrap_pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_out     <= 1'b0;
      wrap_pulse <= 1'b0;
    end else begin
      sq_out     <= (step_q != '0) && (acc >= half_q);
      wrap_pulse <= wrap_now;
    end
  end

endmodule

// File: rtl/nco_sqwave.sv
module nco_sqwave #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bin_mode,
  input  logic [ACC_W-1:0] step_in,
  input  logic [ACC_W-1:0] modulus_in,
  output logic             sq_out,
  output logic             wrap_pulse
);
  localparam int MOD_W = ACC_W + 1;

  logic [ACC_W-1:0] step_q;
  logic [ACC_W-1:0] half_q;
  logic [MOD_W-1:0] mod_q;
  logic [ACC_W-1:0] acc;
  logic             wrap_now;
  logic             load_en;

  // capture new settings on a wrap, or continuously while idle at step zero
  assign load_en = wrap_now || (step_q == '0);

  nco_cfg_hold #(.ACC_W(ACC_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .bin_mode   (bin_mode),
    .step_in    (step_in),
    .modulus_in (modulus_in),
    .step_q     (step_q),
    .half_q     (half_q),
    .mod_q      (mod_q)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .step_q   (step_q),
    .mod_q    (mod_q),
    .acc      (acc),
    .wrap_now (wrap_now)
  );

  nco_edge_out #(.ACC_W(ACC_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc),
    .half_q     (half_q),
    .step_q     (step_q),
    .wrap_now   (wrap_now),
    .sq_out     (sq_out),
    .wrap_pulse (wrap_pulse)
  );

endmodule

// File: rtl/nco_sqwave_chk.sv
module nco_sqwave_chk #(
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [ACC_W-1:0] step_q,
  input logic [ACC_W-1:0] half_q,
  input logic             wrap_now,
  input logic             sq_out,
  input logic             wrap_pulse
);

  // R1: reset drives both outputs low on the following edge
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sq_out && !wrap_pulse));

  // R6: a held step is always below half the modulus, or zero
  a_r6_step_clamped: assert property (@(posedge clk) disable iff (rst)
    (step_q == '0) || (step_q < half_q));

  // R7: a zero step keeps the square wave low
  a_r7_zero_low: assert property (@(posedge clk) disable iff (rst)
    (step_q == '0) |=> !sq_out);

  // R8: settings stay put between wraps while running
  a_r8_cfg_held: assert property (@(posedge clk) disable iff (rst)
    (!wrap_now && step_q != '0) |=> ($stable(step_q) && $stable(half_q)));

endmodule

bind nco_sqwave nco_sqwave_chk #(.ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step_q     (step_q),
  .half_q     (half_q),
  .wrap_now   (wrap_now),
  .sq_out     (sq_out),
  .wrap_pulse (wrap_pulse)
);

// File: tb/sim_nco_sqwave.sv
`timescale 1ns/1ps
module sim_nco_sqwave;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bin_mode = 1'b0;
  logic [W-1:0] step_in = '0;
  logic [W-1:0] modulus_in = '0;
  logic         sq_out;
  logic         wrap_pulse;

  int n_chk = 0;
  int n_err = 0;
  int wraps, highs, gap_min, gap_max, first_at, doubles;

  always #2.5 clk = ~clk;

  nco_sqwave #(.ACC_W(W)) u0 (
    .clk(clk), .rst(rst), .bin_mode(bin_mode),
    .step_in(step_in), .modulus_in(modulus_in),
    .sq_out(sq_out), .wrap_pulse(wrap_pulse)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic bm, input logic [W-1:0] st, input logic [W-1:0] md);
    rst = 1'b1;
    bin_mode = bm;
    step_in = st;
    modulus_in = md;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    int last;
    logic prev;
    last = -1; prev = 1'b0;
    wraps = 0; highs = 0; gap_min = 99999; gap_max = 0; first_at = -1; doubles = 0;
    for (int i = 1; i <= n; i++) begin
      tick();
      if (sq_out) highs++;
      if (wrap_pulse) begin
        wraps++;
        if (first_at < 0) first_at = i;
        if (last >= 0) begin
          if (i - last < gap_min) gap_min = i - last;
          if (i - last > gap_max) gap_max = i - last;
        end
        last = i;
        if (prev) doubles++;
      end
      prev = wrap_pulse;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick();
    tick();
    chk("R1", "sq_out in reset", int'(sq_out), 0);
    chk("R1", "wrap_pulse in reset", int'(wrap_pulse), 0);
    apply(1'b1, 16'h1000, 16'd10);
    run(12);
    chk("R3", "sq_out high before mid-run reset", int'(sq_out), 1);
    rst = 1'b1;
    tick();
    chk("R1", "sq_out after mid-run reset", int'(sq_out), 0);
    rst = 1'b0;
    run(16);
    chk("R1", "first wrap after restart", first_at, 16);
  endtask

  task automatic t_binary();
    apply(1'b1, 16'h1000, 16'd10);
    run(160);
    chk("R2", "binary wraps", wraps, 10);
    chk("R3", "binary high cycles", highs, 80);
    chk("R5", "binary min gap", gap_min, 16);
    chk("R5", "binary max gap", gap_max, 16);
    chk("R9", "binary first pulse tick", first_at, 16);
  endtask

  task automatic t_arbitrary();
    apply(1'b0, 16'd3, 16'd10);
    run(100);
    chk("R2", "3/10 wraps", wraps, 30);
    chk("R4", "3/10 high cycles", highs, 50);
    chk("R5", "3/10 min gap", gap_min, 3);
    chk("R5", "3/10 max gap", gap_max, 4);
    chk("R9", "3/10 first pulse tick", first_at, 4);
    chk("R9", "back-to-back pulses", doubles, 0);
  endtask

  task automatic t_integer_ratio();
    apply(1'b0, 16'd3, 16'd12);
    run(120);
    chk("R2", "3/12 wraps", wraps, 30);
    chk("R4", "3/12 high cycles", highs, 60);
    chk("R5", "3/12 min gap", gap_min, 4);
    chk("R5", "3/12 max gap", gap_max, 4);
  endtask

  task automatic t_clamp();
    apply(1'b0, 16'd7, 16'd10);
    run(100);
    chk("R6", "step 7 clamped wraps", wraps, 40);
    chk("R6", "step 7 clamped highs", highs, 40);
    apply(1'b0, 16'd5, 16'd10);
    run(100);
    chk("R6", "step 5 clamped wraps", wraps, 40);
  endtask

  task automatic t_zero();
    apply(1'b0, 16'd0, 16'd10);
    run(50);
    chk("R7", "zero step wraps", wraps, 0);
    chk("R7", "zero step highs", highs, 0);
    step_in = 16'd3;
    run(40);
    chk("R7", "wraps after leaving zero", wraps, 11);
  endtask

  task automatic t_capture();
    int cnt;
    apply(1'b1, 16'h1000, 16'd10);
    cnt = 0;
    do begin tick(); cnt++; end while (!wrap_pulse && cnt < 100);
    repeat (3) tick();
    step_in = 16'h2000;
    cnt = 3;
    do begin tick(); cnt++; end while (!wrap_pulse && cnt < 100);
    chk("R8", "interval after mid-period change", cnt, 16);
    cnt = 0;
    do begin tick(); cnt++; end while (!wrap_pulse && cnt < 100);
    chk("R8", "interval with new step", cnt, 8);
    // change lands on the very edge of the next wrap
    repeat (7) tick();
    step_in = 16'h4000;
    tick();
    chk("R8", "pulse on same-edge capture", int'(wrap_pulse), 1);
    cnt = 0;
    do begin tick(); cnt++; end while (!wrap_pulse && cnt < 100);
    chk("R8", "interval after same-edge capture", cnt, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_binary();
    t_arbitrary();
    t_integer_ratio();
    t_clamp();
    t_zero();
    t_capture();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule